// File: doc/BRIEF.md
# Register-Cached Top-of-Stack Unit

This unit holds a 16-bit, upward-growing operand stack for an execution unit. The four newest words live in hardware registers, so most pushes and pops finish in one cycle without touching memory. Older words sit in data memory just above a base address. When a push arrives with every register slot in use, the oldest register word is written to memory first. When a pop or a two-operand request finds too few words in registers, words are read back from memory first. The execution unit sees none of this except a ready signal that drops while a memory transfer is in flight.

The stack position is kept as two parts: a memory pointer to the highest memory word in use, and a small count of the words held in registers. Their sum is the logical stack pointer. A base address marks the empty stack, and a limit address marks the highest position the stack may reach. A push at the limit and a pop from an empty stack are refused, and each raises a one-cycle flag.

Top module: `tos_cache`

## Requirements
- R1: After reset the register count is 0, the memory pointer and the stack pointer equal `base_addr`, `ready` is 1 and `mem_req` is 0.
- R2: The stack pointer always equals the memory pointer plus the register count, and it moves by exactly +1 on a push and -1 on a pop.
- R3: A push (op_kind 1) with fewer than four words in registers finishes in one cycle with no memory traffic. The pushed word becomes `top_word` and the count rises by 1.
- R4: A push with four words in registers first writes the oldest register word to address memory pointer + 1, then adds 1 to the memory pointer and places the new word on top. The count stays at 4.
- R5: A pop (op_kind 2) with at least one word in registers finishes with no memory traffic. It lowers the count by 1 and returns the old top word on `popped_word`.
- R6: A pop with no words in registers reads the word at the memory pointer, returns it on `popped_word` and lowers the memory pointer by 1. The count stays at 0.
- R7: A pair request (op_kind 3) with fewer than two words in registers reads memory from the memory pointer downward until two words are in registers. The word from the higher address ends up nearer the top, and `top_word`/`next_word` then show the two newest stack words.
- R8: A push when the stack pointer equals `limit_addr` is ignored and sets `ovf_flag` for the following cycle. The stack pointer never exceeds `limit_addr`.
- R9: A pop when the stack pointer equals `base_addr`, or a pair request with fewer than two words on the stack, is ignored and sets `unf_flag` for the following cycle.
- R10: `ready` is low from the cycle after a transfer starts until the acknowledged transfer completes. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. Each accepted operation gives exactly one `op_done` pulse, and a refused one gives none.
- R11: The register count never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 16 | Address of the empty-stack position |
| limit_addr | input | 16 | Highest allowed stack pointer |
| op_valid | input | 1 | Operation request, taken when `ready` is 1 |
| op_kind | input | 2 | 0 none, 1 push, 2 pop, 3 ensure two words in registers |
| push_word | input | 16 | Data for a push |
| ready | output | 1 | Unit can accept an operation this cycle |
| top_word | output | 16 | Newest stack word (valid when count >= 1) |
| next_word | output | 16 | Second newest stack word (valid when count >= 2) |
| popped_word | output | 16 | Word removed by the last completed pop |
| op_done | output | 1 | One-cycle pulse when an accepted operation completes |
| ovf_flag | output | 1 | One-cycle pulse after a refused push |
| unf_flag | output | 1 | One-cycle pulse after a refused pop or pair request |
| sm_ptr | output | 16 | Highest memory word in use |
| sr_count | output | 3 | Number of stack words held in registers |
| sp_ptr | output | 16 | Logical stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr | output | 16 | Memory address of the transfer |
| mem_wdata | output | 16 | Spill data |
| mem_rdata | input | 16 | Fill data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The hardest case to reach is a pair request or a pop that finds the register count at 0 or 1 while memory still holds words. A plain run of pushes and pops never leaves the registers empty above stored words. The stimulus therefore pushes past four words so that spills happen, then pops the registers dry. From there it issues single pops and pair requests, which must read memory in the right address order. The memory model acknowledges after a latency that the tests vary, so both the idle time of `ready` and the holding of the request are checked over transfers of different lengths.

// File: rtl/tos_pkg.sv
package tos_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PUSH = 2'd1, OP_POP = 2'd2, OP_PAIR = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SPILL, ST_FILL} st_e;
  typedef enum logic [1:0] {RB_HOLD, RB_PUSH, RB_POP, RB_FILL} rb_cmd_e;
  typedef enum logic [1:0] {PT_HOLD, PT_INC, PT_DEC} pt_cmd_e;
endpackage

// File: rtl/tos_regbank.sv
module tos_regbank
  import tos_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rb_cmd_e       cmd,
  input  logic [DW-1:0] in_word,
  input  logic [CW-1:0] fill_idx,
  input  logic [DW-1:0] fill_word,
  output logic [DW-1:0] top_word,
  output logic [DW-1:0] next_word,
  output logic [DW-1:0] deep_word
);
  logic [NREG-1:0][DW-1:0] word_q;
  logic [NREG-1:0][DW-1:0] word_d;

  // slot 0 is the newest word; higher slots are older
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] from_above;
    logic [DW-1:0] from_below;
    if (g == 0) begin : g_first
      assign from_above = in_word;
    end else begin : g_inner
      assign from_above = word_q[g-1];
    end
    if (g == NREG - 1) begin : g_last
      assign from_below = '0;
    end else begin : g_mid
      assign from_below = word_q[g+1];
    end
    assign word_d[g] = (cmd == RB_PUSH) ? from_above :
                       (cmd == RB_POP)  ? from_below :
                       ((cmd == RB_FILL) && (fill_idx == CW'(g))) ? fill_word :
                       word_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign top_word  = word_q[0];
  assign next_word = word_q[1];
  assign deep_word = word_q[NREG-1];

  // R3
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == RB_PUSH) |=> (top_word == $past(in_word)));
endmodule

// File: rtl/tos_ptrs.sv
module tos_ptrs
  import tos_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 4,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  pt_cmd_e       sm_cmd,
  input  pt_cmd_e       sr_cmd,
  output logic [AW-1:0] sm,
  output logic [CW-1:0] sr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sm <= base_addr;
      sr <= '0;
    end else begin
      case (sm_cmd)
        PT_INC:  sm <= sm + 1'b1;
        PT_DEC:  sm <= sm - 1'b1;
        default: sm <= sm;
      endcase
      case (sr_cmd)
        PT_INC:  sr <= sr + 1'b1;
        PT_DEC:  sr <= sr - 1'b1;
        default: sr <= sr;
      endcase
    end
  end

  // R11
  sr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr <= CW'(NREG));
endmodule

// File: rtl/tos_cache.sv
module tos_cache
  import tos_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] limit_addr,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [DW-1:0] push_word,
  output logic          ready,
  output logic [DW-1:0] top_word,
  output logic [DW-1:0] next_word,
  output logic [DW-1:0] popped_word,
  output logic          op_done,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic [AW-1:0] sm_ptr,
  output logic [2:0]    sr_count,
  output logic [AW-1:0] sp_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int CW = 3;
  localparam logic [CW-1:0] SR_FULL = CW'(NREG);

  function automatic logic [AW-1:0] sp_of(input logic [AW-1:0] sm, input logic [CW-1:0] sr);
    return sm + AW'(sr);
  endfunction

  function automatic logic has_room(input logic [AW-1:0] sp, input logic [AW-1:0] lim);
    return sp < lim;
  endfunction

  function automatic logic [AW-1:0] depth_of(input logic [AW-1:0] sp, input logic [AW-1:0] base);
    return sp - base;
  endfunction

  st_e           st_q, st_d;
  rb_cmd_e       rb_cmd;
  pt_cmd_e       sm_cmd, sr_cmd;
  logic [DW-1:0] rb_in;
  logic [DW-1:0] fill_word;
  logic [DW-1:0] deep_word;
  logic [DW-1:0] pend_word_q, pend_word_d;
  logic          pend_pop_q, pend_pop_d;
  logic [DW-1:0] popped_q, popped_d;
  logic          done_d, ovf_d, unf_d;
  logic [AW-1:0] sm;
  logic [CW-1:0] sr;
  logic [AW-1:0] sp;

  // named internal events
  logic acc_any, acc_push, acc_pop, acc_pair;
  logic push_rej, pop_rej, pair_rej;
  logic xfer_done;

  assign sp        = sp_of(sm, sr);
  assign ready     = (st_q == ST_IDLE);
  assign acc_any   = op_valid && ready;
  assign acc_push  = acc_any && (op_e'(op_kind) == OP_PUSH);
  assign acc_pop   = acc_any && (op_e'(op_kind) == OP_POP);
  assign acc_pair  = acc_any && (op_e'(op_kind) == OP_PAIR);
  assign push_rej  = acc_push && !has_room(sp, limit_addr);
  assign pop_rej   = acc_pop && (sp == base_addr);
  assign pair_rej  = acc_pair && (depth_of(sp, base_addr) < AW'(2));
  assign xfer_done = mem_req && mem_ack;

  always_comb begin
    st_d        = st_q;
    rb_cmd      = RB_HOLD;
    sm_cmd      = PT_HOLD;
    sr_cmd      = PT_HOLD;
    pend_word_d = pend_word_q;
    pend_pop_d  = pend_pop_q;
    popped_d    = popped_q;
    done_d      = 1'b0;
    ovf_d       = 1'b0;
    unf_d       = 1'b0;
    fill_word   = mem_rdata;
    unique case (st_q)
      ST_IDLE: begin
        if (push_rej) begin
          ovf_d = 1'b1;
        end else if (acc_push) begin
          if (sr == SR_FULL) begin
            st_d        = ST_SPILL;
            pend_word_d = push_word;
          end else begin
            rb_cmd = RB_PUSH;
            sr_cmd = PT_INC;
            done_d = 1'b1;
          end
        end else if (pop_rej || pair_rej) begin
          unf_d = 1'b1;
        end else if (acc_pop) begin
          if (sr == '0) begin
            st_d       = ST_FILL;
            pend_pop_d = 1'b1;
          end else begin
            popped_d = top_word;
            rb_cmd   = RB_POP;
            sr_cmd   = PT_DEC;
            done_d   = 1'b1;
          end
        end else if (acc_pair) begin
          if (sr < CW'(2)) begin
            st_d       = ST_FILL;
            pend_pop_d = 1'b0;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_SPILL: begin
        if (xfer_done) begin
          rb_cmd = RB_PUSH;
          sm_cmd = PT_INC;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (xfer_done) begin
          sm_cmd = PT_DEC;
          if (pend_pop_q) begin
            popped_d = mem_rdata;
            done_d   = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            rb_cmd = RB_FILL;
            sr_cmd = PT_INC;
            if (sr >= CW'(1)) begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      pend_word_q <= '0;
      pend_pop_q  <= 1'b0;
      popped_q    <= '0;
      op_done     <= 1'b0;
      ovf_flag    <= 1'b0;
      unf_flag    <= 1'b0;
    end else begin
      st_q        <= st_d;
      pend_word_q <= pend_word_d;
      pend_pop_q  <= pend_pop_d;
      popped_q    <= popped_d;
      op_done     <= done_d;
      ovf_flag    <= ovf_d;
      unf_flag    <= unf_d;
    end
  end

  assign rb_in = (st_q == ST_SPILL) ? pend_word_q : push_word;

  tos_regbank #(.DW(DW), .NREG(NREG), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (rb_cmd),
    .in_word   (rb_in),
    .fill_idx  (sr),
    .fill_word (fill_word),
    .top_word  (top_word),
    .next_word (next_word),
    .deep_word (deep_word)
  );

  tos_ptrs #(.AW(AW), .NREG(NREG), .CW(CW)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_addr (base_addr),
    .sm_cmd    (sm_cmd),
    .sr_cmd    (sr_cmd),
    .sm        (sm),
    .sr        (sr)
  );

  assign mem_req     = (st_q != ST_IDLE);
  assign mem_we      = (st_q == ST_SPILL);
  assign mem_addr    = (st_q == ST_SPILL) ? sm + 1'b1 : sm;
  assign mem_wdata   = deep_word;
  assign popped_word = popped_q;
  assign sm_ptr      = sm;
  assign sr_count    = sr;
  assign sp_ptr      = sp;

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R4
  spill_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (sr_count == 3'(NREG)));
  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_rej |=> (ovf_flag && $stable(sp_ptr)));
  // R8
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ptr <= limit_addr);
  // R9
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ptr >= base_addr);
endmodule

// File: tb/sim_tos_cache.sv
module sim_tos_cache;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DB = 16'h0040;
  localparam logic [15:0] SL = 16'h004A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] base_addr = DB;
  logic [15:0] limit_addr = SL;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [15:0] push_word = '0;
  logic        ready, op_done, ovf_flag, unf_flag;
  logic [15:0] top_word, next_word, popped_word, sm_ptr, sp_ptr;
  logic [2:0]  sr_count;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tos_cache u0 (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .limit_addr(limit_addr),
    .op_valid(op_valid), .op_kind(op_kind), .push_word(push_word),
    .ready(ready), .top_word(top_word), .next_word(next_word),
    .popped_word(popped_word), .op_done(op_done), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .sm_ptr(sm_ptr), .sr_count(sr_count), .sp_ptr(sp_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory model with adjustable acknowledge latency
  logic [15:0] mem [0:255];
  int lat = 0;
  int wcnt = 0;
  int n_wr = 0, n_rd = 0, n_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack <= 1'b1;
        wcnt    <= 0;
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem[mem_addr[7:0]];
          n_rd <= n_rd + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
    if (rst_n && op_done) n_done <= n_done + 1;
  end

  int n_chk = 0, n_bad = 0;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference stack, independent of the design
  logic [15:0] rs [0:63];
  int rdepth = 0, rsr = 0, rsm = 0;

  task automatic run_op(input logic [1:0] kind, input logic [15:0] data);
    int w0, r0, d0, ew, er;
    bit eovf, eunf, acc;
    logic [15:0] epop;
    logic seen_ovf, seen_unf, rdy1;
    ew = 0; er = 0; eovf = 0; eunf = 0; acc = 1; epop = popped_word;
    if (kind == 2'd1) begin
      if (int'(DB) + rdepth >= int'(SL)) begin eovf = 1; acc = 0; end
      else begin
        rs[rdepth] = data; rdepth++;
        if (rsr == 4) begin rsm++; ew = 1; end else rsr++;
      end
    end else if (kind == 2'd2) begin
      if (rdepth == 0) begin eunf = 1; acc = 0; end
      else begin
        epop = rs[rdepth-1]; rdepth--;
        if (rsr == 0) begin rsm--; er = 1; end else rsr--;
      end
    end else if (kind == 2'd3) begin
      if (rdepth < 2) begin eunf = 1; acc = 0; end
      else while (rsr < 2) begin rsm--; rsr++; er++; end
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    w0 = n_wr; r0 = n_rd; d0 = n_done;
    op_valid = 1'b1; op_kind = kind; push_word = data;
    @(negedge clk);
    op_valid = 1'b0; op_kind = 2'd0;
    seen_ovf = ovf_flag; seen_unf = unf_flag; rdy1 = ready;
    while (!ready) @(negedge clk);
    @(negedge clk);
    check_eq("R8 overflow flag", 32'(seen_ovf), 32'(eovf));
    check_eq("R9 underflow flag", 32'(seen_unf), 32'(eunf));
    check_eq("R10 done pulses", 32'(n_done - d0), 32'(acc));
    if (ew + er > 0) check_eq("R10 ready low during transfer", 32'(rdy1), 32'd0);
    check_eq(ew > 0 ? "R4 spill writes" : "R3 writes", 32'(n_wr - w0), 32'(ew));
    check_eq(kind == 2'd3 ? "R7 fill reads" : "R6 fill reads", 32'(n_rd - r0), 32'(er));
    check_eq("R2 register count", 32'(sr_count), 32'(rsr));
    check_eq("R2 memory pointer", 32'(sm_ptr), 32'(rsm));
    check_eq("R2 stack pointer", 32'(sp_ptr), 32'(int'(DB) + rdepth));
    check_eq("R11 count bound", 32'(sr_count <= 3'd4), 32'd1);
    if (rsr >= 1) check_eq(kind == 2'd3 ? "R7 top word" : "R3 top word", 32'(top_word), 32'(rs[rdepth-1]));
    if (rsr >= 2) check_eq(kind == 2'd3 ? "R7 next word" : "R5 next word", 32'(next_word), 32'(rs[rdepth-2]));
    if (kind == 2'd2 && acc) check_eq(er > 0 ? "R6 popped word" : "R5 popped word", 32'(popped_word), 32'(epop));
    if (ew > 0) check_eq("R4 spilled data", 32'(mem[rsm[7:0]]), 32'(rs[rsm - int'(DB) - 1]));
  endtask

  task automatic t_reset();
    check_eq("R1 count", 32'(sr_count), 32'd0);
    check_eq("R1 memory pointer", 32'(sm_ptr), 32'(DB));
    check_eq("R1 stack pointer", 32'(sp_ptr), 32'(DB));
    check_eq("R1 ready", 32'(ready), 32'd1);
    check_eq("R1 no request", 32'(mem_req), 32'd0);
    rsm = int'(DB);
  endtask

  task automatic t_fast_push();  // R3
    for (int i = 0; i < 4; i++) run_op(2'd1, 16'hA100 + 16'(i));
  endtask

  task automatic t_spill();  // R4, R10 with two latencies
    lat = 0; run_op(2'd1, 16'hB200);
    run_op(2'd1, 16'hB201);
    lat = 3; run_op(2'd1, 16'hB202);
  endtask

  task automatic t_pop_regs();  // R5
    lat = 0;
    for (int i = 0; i < 4; i++) run_op(2'd2, 16'h0);
  endtask

  task automatic t_pop_fill();  // R6
    lat = 2; run_op(2'd2, 16'h0);
  endtask

  task automatic t_pair_from_empty_regs();  // R7: count 0, two reads
    lat = 1; run_op(2'd3, 16'h0);
    lat = 0; run_op(2'd2, 16'h0); run_op(2'd2, 16'h0);
  endtask

  task automatic t_underflow();  // R9
    run_op(2'd2, 16'h0);
    run_op(2'd3, 16'h0);
    run_op(2'd1, 16'hC300);
    run_op(2'd3, 16'h0);
    run_op(2'd2, 16'h0);
  endtask

  task automatic t_pair_from_one();  // R7: count 1, one read
    for (int i = 0; i < 6; i++) run_op(2'd1, 16'hD400 + 16'(i));
    for (int i = 0; i < 3; i++) run_op(2'd2, 16'h0);
    lat = 2; run_op(2'd3, 16'h0);
    lat = 0;
  endtask

  task automatic t_overflow();  // R8
    while (rdepth < 10) run_op(2'd1, 16'hE500 + 16'(rdepth));
    run_op(2'd1, 16'hFFFF);
    run_op(2'd1, 16'hFFFE);
    run_op(2'd2, 16'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired, actual=hung expected=progress");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_push();
    t_spill();
    t_pop_regs();
    t_pop_fill();
    t_pair_from_empty_regs();
    t_underflow();
    t_pair_from_one();
    t_overflow();
    finish_run();
  end
endmodule